// File: doc/BRIEF.md
# Four-Phase Interlocked Request/Acknowledge Bus Pair

This block joins a command-side initiator and a register-file responder that run on two unrelated clocks. They share a small parallel bus: an address, a write-select line, a write-data path, a read-data return path, and a request/acknowledge pair. Every single-word transfer uses four interlocked edges. The request rises. The acknowledge answers. The request falls. The acknowledge falls. No edge can happen until the other side has shown the one before it.

The initiator puts the target address, the direction and any write data on the bus first. It then counts a fixed settle interval so that the responder's address decode can resolve, and only then raises the request. Each side sees the other's handshake line only through a two-flop synchronizer clocked in its own domain. The responder holds a word-addressed register file. On a write it stores the word. On a read it presents the word and keeps it steady for as long as it holds the acknowledge. The initiator signals completion with a one-cycle pulse, and it does so only after the acknowledge has dropped.

Top module: `hsb_top`

## Requirements
- R1: After reset, cmd_ready is 1, done is 0, rd_data is 0, and every register-file word reads back as 0.
- R2: A command is taken on a master clock edge where cmd_valid and cmd_ready are both 1. From the next cycle, cmd_ready stays 0 until the cycle in which done is 1.
- R3: Address, direction and write data are on the bus for at least SETTLE master cycles before the request rises. They stay unchanged while the request is high. A transfer therefore lasts more than SETTLE+3 master cycles from acceptance to done.
- R4: The request rises only while the acknowledge is low, and it falls only while the acknowledge is high.
- R5: A read returns the word last written to that address. The read data does not change while the acknowledge is held high.
- R6: The acknowledge rises only while the request is high, and it falls only after the request has gone low.
- R7: done is a single-cycle pulse. On a read, rd_data carries the word read, from the cycle of done onward. A write leaves rd_data unchanged.
- R8: cmd_valid is ignored while cmd_ready is 0. A command offered during a transfer changes no register-file word.
- R9: Each of the 2^ADDR_W addresses selects its own word. This includes address 0 and the all-ones address. A write changes no other word.
- R10: The bus address changes only while both the request and the acknowledge are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Initiator-side clock |
| rst_m | input | 1 | Synchronous active-high reset, initiator domain |
| clk_s | input | 1 | Responder-side clock, unrelated to clk_m |
| rst_s | input | 1 | Synchronous active-high reset, responder domain |
| cmd_valid | input | 1 | Command offered |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Target word address |
| cmd_wdata | input | DATA_W | Word to write |
| cmd_ready | output | 1 | Initiator idle, able to take a command |
| done | output | 1 | One-cycle pulse when a transfer ends |
| rd_data | output | DATA_W | Word returned by the last read |

## Verification
The assertions assume that both resets are applied together and held for several cycles of each clock. They also assume that cmd_valid, cmd_write, cmd_addr and cmd_wdata change only away from clk_m edges. The bench drives every command input on the falling edge of clk_m and releases both resets together after a common hold time. It drops cmd_valid while a transfer is in flight, so no command is offered exactly at the edge where cmd_ready returns.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

    localparam int unsigned DEF_ADDR_W = 4;
    localparam int unsigned DEF_DATA_W = 16;
    localparam int unsigned DEF_SETTLE = 2;
    localparam int unsigned DEF_SYNC   = 2;

    typedef enum logic [1:0] {
        M_IDLE    = 2'd0,
        M_SETTLE  = 2'd1,
        M_REQ     = 2'd2,
        M_RELEASE = 2'd3
    } m_state_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_HOLD = 1'b1
    } s_state_e;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
    parameter int unsigned STAGES = hsb_pkg::DEF_SYNC
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[0] <= 1'b0;
                else     pipe[0] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) pipe[i] <= 1'b0;
                else     pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/hsb_master.sv
module hsb_master
    import hsb_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned SETTLE = DEF_SETTLE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_req,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              ack_sync
);
    localparam int unsigned CW = cnt_width(SETTLE);
    localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

    m_state_e          state;
    logic [CW-1:0]     cnt;
    logic [DATA_W-1:0] cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= M_IDLE;
            cnt       <= '0;
            cap       <= '0;
            rd_data   <= '0;
            done      <= 1'b0;
            bus_addr  <= '0;
            bus_wr    <= 1'b0;
            bus_wdata <= '0;
            bus_req   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                M_IDLE: begin
                    if (cmd_valid) begin
                        bus_addr  <= cmd_addr;
                        bus_wr    <= cmd_write;
                        bus_wdata <= cmd_wdata;
                        cnt       <= '0;
                        state     <= M_SETTLE;
                    end
                end
                M_SETTLE: begin
                    if (cnt == LAST) begin
                        bus_req <= 1'b1;
                        state   <= M_REQ;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                M_REQ: begin
                    if (ack_sync) begin
                        if (!bus_wr) cap <= bus_rdata;
                        bus_req <= 1'b0;
                        state   <= M_RELEASE;
                    end
                end
                M_RELEASE: begin
                    if (!ack_sync) begin
                        if (!bus_wr) rd_data <= cap;
                        done  <= 1'b1;
                        state <= M_IDLE;
                    end
                end
                default: state <= M_IDLE;
            endcase
        end
    end

    assign cmd_ready = (state == M_IDLE);
endmodule

// File: rtl/hsb_slave.sv
module hsb_slave
    import hsb_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              req_sync,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ack
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    s_state_e          state;
    logic [DATA_W-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            bus_rdata <= '0;
            bus_ack   <= 1'b0;
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (req_sync) begin
                        if (bus_wr) regs[bus_addr] <= bus_wdata;
                        else        bus_rdata      <= regs[bus_addr];
                        bus_ack <= 1'b1;
                        state   <= S_HOLD;
                    end
                end
                S_HOLD: begin
                    if (!req_sync) begin
                        bus_ack <= 1'b0;
                        state   <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hsb_top.sv
module hsb_top
    import hsb_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned SETTLE = DEF_SETTLE,
    parameter int unsigned SYNC   = DEF_SYNC
) (
    input  logic              clk_m,
    input  logic              rst_m,
    input  logic              clk_s,
    input  logic              rst_s,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data
);
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_wr;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata;
    logic              bus_req;
    logic              bus_ack;
    logic              req_s;
    logic              ack_m;

    hsb_sync #(.STAGES(SYNC)) u_req_sync (
        .clk(clk_s), .rst(rst_s), .d(bus_req), .q(req_s)
    );

    hsb_sync #(.STAGES(SYNC)) u_ack_sync (
        .clk(clk_m), .rst(rst_m), .d(bus_ack), .q(ack_m)
    );

    hsb_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETTLE(SETTLE)) u_master (
        .clk       (clk_m),
        .rst       (rst_m),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .cmd_ready (cmd_ready),
        .done      (done),
        .rd_data   (rd_data),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_req   (bus_req),
        .bus_rdata (bus_rdata),
        .ack_sync  (ack_m)
    );

    hsb_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slave (
        .clk       (clk_s),
        .rst       (rst_s),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .req_sync  (req_s),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack)
    );
endmodule

// File: rtl/hsb_checker.sv
module hsb_checker #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned SETTLE = 2
) (
    input logic              clk_m,
    input logic              rst_m,
    input logic              clk_s,
    input logic              rst_s,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              done,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_req,
    input logic              bus_ack
);
    logic [15:0] settle_cnt;

    always_ff @(posedge clk_m) begin
        if (rst_m || (cmd_valid && cmd_ready)) settle_cnt <= '0;
        else if (!bus_req && settle_cnt != 16'hFFFF) settle_cnt <= settle_cnt + 1'b1;
    end

    // R3
    a_r3_settle: assert property (@(posedge clk_m) disable iff (rst_m || rst_s)
        $rose(bus_req) |-> (settle_cnt >= 16'(SETTLE)));
    a_r3_hold_fields: assert property (@(posedge clk_m) disable iff (rst_m || rst_s)
        bus_req |-> ($stable(bus_addr) && $stable(bus_wr) && $stable(bus_wdata)));
    // R4
    a_r4_req_rise: assert property (@(posedge clk_m) disable iff (rst_m || rst_s)
        $rose(bus_req) |-> !bus_ack);
    a_r4_req_fall: assert property (@(posedge clk_m) disable iff (rst_m || rst_s)
        $fell(bus_req) |-> bus_ack);
    // R6
    a_r6_ack_rise: assert property (@(posedge clk_s) disable iff (rst_m || rst_s)
        $rose(bus_ack) |-> bus_req);
    a_r6_ack_fall: assert property (@(posedge clk_s) disable iff (rst_m || rst_s)
        $fell(bus_ack) |-> !bus_req);
    // R5
    a_r5_rdata_hold: assert property (@(posedge clk_s) disable iff (rst_m || rst_s)
        ($past(bus_ack) && bus_ack) |-> $stable(bus_rdata));
    // R10
    a_r10_addr_move: assert property (@(posedge clk_m) disable iff (rst_m || rst_s)
        !$stable(bus_addr) |-> (!bus_req && !bus_ack));
    // R7
    a_r7_done_pulse: assert property (@(posedge clk_m) disable iff (rst_m || rst_s)
        done |=> !done);
    // R2
    a_r2_busy_after_take: assert property (@(posedge clk_m) disable iff (rst_m || rst_s)
        (cmd_valid && cmd_ready) |=> !cmd_ready);
endmodule

bind hsb_top hsb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETTLE(SETTLE)) u_chk (
    .clk_m     (clk_m),
    .rst_m     (rst_m),
    .clk_s     (clk_s),
    .rst_s     (rst_s),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .done      (done),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack)
);

// File: tb/hsb_top_test.sv
module hsb_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_S_PERIOD = 14;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int SETTLE = 2;
    localparam int WAIT_MAX = 500;

    logic clk_m = 1'b0;
    logic clk_s = 1'b0;
    logic rst_m = 1'b1;
    logic rst_s = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_write = 1'b0;
    logic [AW-1:0] cmd_addr  = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          cmd_ready;
    logic          done;
    logic [DW-1:0] rd_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2)   clk_m = ~clk_m;
    always #(CLK_S_PERIOD/2) clk_s = ~clk_s;

    hsb_top #(.ADDR_W(AW), .DATA_W(DW), .SETTLE(SETTLE)) uut (
        .clk_m(clk_m), .rst_m(rst_m), .clk_s(clk_s), .rst_s(rst_s),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready), .done(done), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // One transfer; waits for done and checks the pulse and busy window.
    task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rdv, output int cyc);
        int w = 0;
        @(negedge clk_m);
        while (!cmd_ready && w < WAIT_MAX) begin @(negedge clk_m); w++; end
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
        @(negedge clk_m);
        cmd_valid = 1'b0;
        check("R2 ready low after accept", cmd_ready, 0);
        cyc = 1;
        while (!done && cyc < WAIT_MAX) begin
            if (cmd_ready) begin
                n_checks++; n_fails++;
                $display("FAIL R2: got cmd_ready 1 expected 0 before done");
            end
            @(negedge clk_m); cyc++;
        end
        check("R7 done seen", done, 1);
        rdv = rd_data;
        @(negedge clk_m);
        check("R7 done single cycle", done, 0);
    endtask

    task automatic t_reset();
        check("R1 ready after reset", cmd_ready, 1);
        check("R1 done after reset", done, 0);
        check("R1 rd_data after reset", rd_data, 0);
    endtask

    task automatic t_reset_contents();
        logic [DW-1:0] r; int c;
        xfer(1'b0, 4'd9, '0, r, c);
        check("R1 word 9 reads zero", r, 0);
        xfer(1'b0, 4'd0, '0, r, c);
        check("R1 word 0 reads zero", r, 0);
    endtask

    task automatic t_basic_rw();
        logic [DW-1:0] r; int c;
        xfer(1'b1, 4'd3, 16'hA5C3, r, c);
        check("R3 transfer length", (c > SETTLE + 3) ? 1 : 0, 1);
        xfer(1'b0, 4'd3, '0, r, c);
        check("R5 read back word 3", r, 16'hA5C3);
        check("R7 rd_data holds after done", rd_data, 16'hA5C3);
    endtask

    task automatic t_write_keeps_rdata();
        logic [DW-1:0] r; int c;
        xfer(1'b1, 4'd7, 16'h1234, r, c);
        check("R7 write leaves rd_data", rd_data, 16'hA5C3);
    endtask

    task automatic t_boundaries();
        logic [DW-1:0] r; int c;
        xfer(1'b1, 4'd0,  16'hFFFF, r, c);
        xfer(1'b1, 4'd15, 16'h8001, r, c);
        xfer(1'b0, 4'd0,  '0, r, c);
        check("R9 address 0", r, 16'hFFFF);
        xfer(1'b0, 4'd15, '0, r, c);
        check("R9 address 15", r, 16'h8001);
    endtask

    task automatic t_isolation();
        logic [DW-1:0] r; int c;
        for (int i = 0; i < 16; i++) xfer(1'b1, 4'(i), 16'(16'h0100 * i + 16'h5A), r, c);
        for (int i = 15; i >= 0; i--) begin
            xfer(1'b0, 4'(i), '0, r, c);
            check("R9 distinct word", r, 32'(16'(16'h0100 * i + 16'h5A)));
        end
    endtask

    task automatic t_busy_ignored();
        logic [DW-1:0] r; int c = 0;
        @(negedge clk_m);
        while (!cmd_ready && c < WAIT_MAX) begin @(negedge clk_m); c++; end
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 4'd2; cmd_wdata = 16'h2222;
        @(negedge clk_m);
        cmd_addr = 4'd5; cmd_wdata = 16'hDEAD;
        for (int k = 0; k < 3; k++) begin
            check("R8 busy during offer", cmd_ready, 0);
            @(negedge clk_m);
        end
        cmd_valid = 1'b0;
        c = 0;
        while (!done && c < WAIT_MAX) begin @(negedge clk_m); c++; end
        check("R8 first transfer done", done, 1);
        xfer(1'b0, 4'd5, '0, r, c);
        check("R8 offered write ignored", r, 16'h055A);
        xfer(1'b0, 4'd2, '0, r, c);
        check("R8 accepted write landed", r, 16'h2222);
    endtask

    task automatic t_back_to_back();
        logic [DW-1:0] r; int c;
        xfer(1'b1, 4'd6, 16'h0F0F, r, c);
        xfer(1'b0, 4'd6, '0, r, c);
        check("R10 next address after full cycle", r, 16'h0F0F);
        xfer(1'b1, 4'd6, 16'hF0F0, r, c);
        xfer(1'b0, 4'd6, '0, r, c);
        check("R5 overwrite returns latest", r, 16'hF0F0);
    endtask

    initial begin
        repeat (6) @(negedge clk_s);
        @(negedge clk_m);
        rst_m = 1'b0; rst_s = 1'b0;
        @(negedge clk_m);
        t_reset();
        t_reset_contents();
        t_basic_rw();
        t_write_keeps_rdata();
        t_boundaries();
        t_isolation();
        t_busy_ignored();
        t_back_to_back();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_m);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule